// File: doc/BRIEF.md
# Dual Alarm with Shared Interrupt / Frequency Output

This block sits next to a real-time clock's calendar counter and watches its live time. It holds two alarms. Each alarm stores a full time-and-date value, a per-field match-enable mask, an armed bit and a repeat bit. When the calendar announces a new second with `sec_tick`, every armed alarm compares its enabled fields against the live time. On a hit it sets a sticky status flag that software polls and clears. A one-shot alarm disarms itself when it fires. A repeating alarm stays armed, so a partly masked value becomes a periodic interrupt: every minute, every Tuesday, or a fixed time on a fixed date.

A single output pin, `irq_fout`, is shared by two functions. With selector 0 it is the interrupt line, high while any flag whose interrupt enable is set is high. With selectors 1, 2 and 3 it carries a 1 Hz, 4096 Hz or 32768 Hz square wave taken from bits of the prescaler count. No data stream passes through the block. All of its pins are plain control and status lines, with no valid/ready handshake and no back-pressure.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset, `alarm_flag` and `alarm_armed` are all zero and `irq_fout` is low.
- R2: An armed alarm fires only on a cycle with `sec_tick` high, and only when every enabled field equals the live time. Its flag is visible after that clock edge. No tick, or one differing enabled field, means no flag.
- R3: A field whose mask bit is 0 always counts as matching. Time vectors pack, from bit 0 upward: sec[5:0], min[11:6], hour[16:12], date[21:17], month[25:22], year[32:26], weekday[35:33]. Mask bit k enables the k-th field of that list (bit 0 seconds … bit 6 weekday).
- R4: The two alarms are independent. A hit on one never sets the other's flag or changes its armed bit.
- R5: A flag stays set until a cycle with its `clr_flag` bit high. If a hit and a clear fall in the same cycle, the flag ends up set.
- R6: An alarm written with `wr_rpt`=0 clears its armed bit on the edge where it fires and does not fire again until rewritten. With `wr_rpt`=1 it stays armed and fires on every later matching tick.
- R7: A write with `wr_en` high replaces the stored time, mask, armed and repeat bits of the alarm selected by `wr_idx`, and no other alarm.
- R8: With `out_sel`=0, `irq_fout` equals the OR over alarms of (flag AND `irq_en` bit), registered one cycle.
- R9: With `out_sel` set to 1, 2 or 3, `irq_fout` equals `presc[15]`, `presc[3]` or `presc[0]` respectively, registered one cycle, whatever the flags are.
- R10: Clearing an `irq_en` bit keeps its flag set but stops it from driving `irq_fout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse at each second boundary |
| now_time | input | 36 | Live calendar time, packed as in R3 |
| wr_en | input | 1 | Alarm register write strobe |
| wr_idx | input | 1 | Alarm selected by the write |
| wr_time | input | 36 | Alarm time value to store |
| wr_mask | input | 7 | Field match-enable mask to store |
| wr_arm | input | 1 | Armed bit to store |
| wr_rpt | input | 1 | Repeat bit to store |
| clr_flag | input | 2 | Per-alarm flag clear |
| irq_en | input | 2 | Per-alarm interrupt enable |
| out_sel | input | 2 | Output select: 0 interrupt, 1 = 1 Hz, 2 = 4096 Hz, 3 = 32768 Hz |
| presc | input | 16 | Free-running prescaler count |
| alarm_flag | output | 2 | Sticky alarm status flags |
| alarm_armed | output | 2 | Current armed bits |
| irq_fout | output | 1 | Shared interrupt / frequency output |

## Verification
The bench holds a matching time while `sec_tick` stays low. A design that compared on every clock would raise the flag early. It fires a one-shot alarm twice, so an alarm that failed to disarm would flag a second time. It masks every field but the weekday, so a design that ignored the mask or used the wrong field offset would miss the match. It clears a flag in the same cycle as a fresh hit, where clear-wins priority would lose the event. In every output mode it samples `irq_fout` one cycle after the stimulus, which exposes a wrong prescaler tap or a flag leaking into frequency mode.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int FIELD_N = 7;
  localparam int TIME_W  = 36;

  function automatic int fld_w(input int f);
    case (f)
      0: return 6;
      1: return 6;
      2: return 5;
      3: return 5;
      4: return 4;
      5: return 7;
      default: return 3;
    endcase
  endfunction

  function automatic int fld_lo(input int f);
    int acc;
    acc = 0;
    for (int k = 0; k < f; k++) acc += fld_w(k);
    return acc;
  endfunction

  typedef enum logic [1:0] {
    OSEL_IRQ  = 2'd0,
    OSEL_1HZ  = 2'd1,
    OSEL_4K   = 2'd2,
    OSEL_32K  = 2'd3
  } osel_e;
endpackage

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [TIME_W-1:0] now_time,
  input  logic              wr_en,
  input  logic [TIME_W-1:0] wr_time,
  input  logic [FIELD_N-1:0] wr_mask,
  input  logic              wr_arm,
  input  logic              wr_rpt,
  input  logic              clr,
  output logic              flag,
  output logic              armed,
  output logic              rpt
);
  logic [TIME_W-1:0]  tgt_q;
  logic [FIELD_N-1:0] mask_q;
  logic [FIELD_N-1:0] fld_ok;
  logic               hit;

  // per-field comparator; a disabled field is a wildcard
  for (genvar f = 0; f < FIELD_N; f++) begin : g_fld
    localparam int LO = fld_lo(f);
    localparam int W  = fld_w(f);
    assign fld_ok[f] = !mask_q[f] || (now_time[LO +: W] == tgt_q[LO +: W]);
  end

  assign hit = sec_tick && armed && (&fld_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      mask_q <= '0;
      armed  <= 1'b0;
      rpt    <= 1'b0;
    end else if (wr_en) begin
      tgt_q  <= wr_time;
      mask_q <= wr_mask;
      armed  <= wr_arm;
      rpt    <= wr_rpt;
    end else if (hit && !rpt) begin
      armed  <= 1'b0;
    end
  end

  // a new hit outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/alarm_out_mux.sv
module alarm_out_mux
  import alarm_irq_pkg::*;
#(
  parameter int PRE_W    = 16,
  parameter int TAP_1HZ  = 15,
  parameter int TAP_4K   = 3,
  parameter int TAP_32K  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       out_sel,
  input  logic [PRE_W-1:0] presc,
  input  logic             irq_req,
  output logic             pin
);
  logic nxt;

  always_comb begin
    case (osel_e'(out_sel))
      OSEL_1HZ: nxt = presc[TAP_1HZ];
      OSEL_4K:  nxt = presc[TAP_4K];
      OSEL_32K: nxt = presc[TAP_32K];
      default:  nxt = irq_req;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= nxt;
  end
endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
  import alarm_irq_pkg::*;
#(
  parameter int N_ALARM = 2,
  parameter int PRE_W   = 16,
  parameter int TAP_1HZ = 15,
  parameter int TAP_4K  = 3,
  parameter int TAP_32K = 0,
  localparam int IDX_W  = (N_ALARM > 1) ? $clog2(N_ALARM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [TIME_W-1:0]  now_time,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TIME_W-1:0]  wr_time,
  input  logic [FIELD_N-1:0] wr_mask,
  input  logic               wr_arm,
  input  logic               wr_rpt,
  input  logic [N_ALARM-1:0] clr_flag,
  input  logic [N_ALARM-1:0] irq_en,
  input  logic [1:0]         out_sel,
  input  logic [PRE_W-1:0]   presc,
  output logic [N_ALARM-1:0] alarm_flag,
  output logic [N_ALARM-1:0] alarm_armed,
  output logic               irq_fout
);
  logic [N_ALARM-1:0] rpt_vec;
  logic               irq_req;

  for (genvar a = 0; a < N_ALARM; a++) begin : g_alm
    alarm_unit u_alm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .now_time (now_time),
      .wr_en    (wr_en && (wr_idx == IDX_W'(a))),
      .wr_time  (wr_time),
      .wr_mask  (wr_mask),
      .wr_arm   (wr_arm),
      .wr_rpt   (wr_rpt),
      .clr      (clr_flag[a]),
      .flag     (alarm_flag[a]),
      .armed    (alarm_armed[a]),
      .rpt      (rpt_vec[a])
    );
  end

  assign irq_req = |(alarm_flag & irq_en);

  alarm_out_mux #(
    .PRE_W   (PRE_W),
    .TAP_1HZ (TAP_1HZ),
    .TAP_4K  (TAP_4K),
    .TAP_32K (TAP_32K)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .out_sel (out_sel),
    .presc   (presc),
    .irq_req (irq_req),
    .pin     (irq_fout)
  );
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk #(
  parameter int N_ALARM = 2,
  parameter int PRE_W   = 16,
  parameter int TAP_1HZ = 15,
  parameter int TAP_4K  = 3,
  parameter int TAP_32K = 0,
  parameter int IDX_W   = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sec_tick,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [N_ALARM-1:0] clr_flag,
  input logic [N_ALARM-1:0] irq_en,
  input logic [1:0]         out_sel,
  input logic [PRE_W-1:0]   presc,
  input logic [N_ALARM-1:0] alarm_flag,
  input logic [N_ALARM-1:0] alarm_armed,
  input logic [N_ALARM-1:0] rpt_vec,
  input logic               irq_fout
);
  for (genvar a = 0; a < N_ALARM; a++) begin : g_a
    // R2: flags only rise on a second tick
    assert_flag_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag[a]) |-> $past(sec_tick));

    // R5: a flag without a clear stays set
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(alarm_flag[a]) && !$past(clr_flag[a])) |-> alarm_flag[a]);

    // R6: one-shot alarm disarms as it fires
    assert_oneshot_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(alarm_flag[a]) && !$past(rpt_vec[a]) && !$past(wr_en)) |-> !alarm_armed[a]);
  end

  // R8: interrupt mode follows enabled flags one cycle later
  assert_irq_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_sel) == 2'd0) |-> irq_fout == $past(|(alarm_flag & irq_en)));

  // R9: frequency taps
  assert_fout_1hz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_sel) == 2'd1) |-> irq_fout == $past(presc[TAP_1HZ]));
  assert_fout_4k_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_sel) == 2'd2) |-> irq_fout == $past(presc[TAP_4K]));
  assert_fout_32k_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_sel) == 2'd3) |-> irq_fout == $past(presc[TAP_32K]));

  // R1: outputs quiet on leaving reset
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (alarm_flag == '0 && alarm_armed == '0 && !irq_fout));

  wire unused_ok = ^wr_idx;
endmodule

bind alarm_irq_top alarm_irq_chk #(
  .N_ALARM (N_ALARM),
  .PRE_W   (PRE_W),
  .TAP_1HZ (TAP_1HZ),
  .TAP_4K  (TAP_4K),
  .TAP_32K (TAP_32K),
  .IDX_W   (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .clr_flag    (clr_flag),
  .irq_en      (irq_en),
  .out_sel     (out_sel),
  .presc       (presc),
  .alarm_flag  (alarm_flag),
  .alarm_armed (alarm_armed),
  .rpt_vec     (rpt_vec),
  .irq_fout    (irq_fout)
);

// File: tb/tb_alarm_irq_top.sv
module tb_alarm_irq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [35:0] now_time = '0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_idx = '0;
  logic [35:0] wr_time = '0;
  logic [6:0]  wr_mask = '0;
  logic        wr_arm = 1'b0;
  logic        wr_rpt = 1'b0;
  logic [1:0]  clr_flag = '0;
  logic [1:0]  irq_en = '0;
  logic [1:0]  out_sel = '0;
  logic [15:0] presc = '0;
  logic [1:0]  alarm_flag;
  logic [1:0]  alarm_armed;
  logic        irq_fout;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  alarm_irq_top dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now_time(now_time),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_time(wr_time), .wr_mask(wr_mask),
    .wr_arm(wr_arm), .wr_rpt(wr_rpt), .clr_flag(clr_flag), .irq_en(irq_en),
    .out_sel(out_sel), .presc(presc), .alarm_flag(alarm_flag),
    .alarm_armed(alarm_armed), .irq_fout(irq_fout)
  );

  function automatic logic [35:0] mk(input int wd, input int yr, input int mo,
                                     input int dt, input int hr, input int mi,
                                     input int se);
    return {wd[2:0], yr[6:0], mo[3:0], dt[4:0], hr[4:0], mi[5:0], se[5:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_alarm(input int idx, input logic [35:0] t, input logic [6:0] m,
                             input logic arm, input logic rp);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[0:0]; wr_time = t; wr_mask = m; wr_arm = arm; wr_rpt = rp;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic clear(input logic [1:0] c);
    @(negedge clk); clr_flag = c;
    @(negedge clk); clr_flag = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags", alarm_flag, 0);
    chk("R1 armed", alarm_armed, 0);
    chk("R1 pin", irq_fout, 0);
  endtask

  task automatic t_full_match_oneshot();
    logic [35:0] t;
    t = mk(2, 25, 3, 21, 5, 23, 0);
    write_alarm(0, t, 7'h7F, 1'b1, 1'b0);
    chk("R7 armed after write", alarm_armed, 2'b01);
    now_time = t;
    cyc(3);
    chk("R2 no tick no flag", alarm_flag, 0);
    now_time = mk(2, 25, 3, 21, 5, 24, 0);
    tick();
    chk("R2 minute differs", alarm_flag, 0);
    now_time = t;
    tick();
    chk("R2 full match flag", alarm_flag, 2'b01);
    chk("R6 oneshot disarmed", alarm_armed, 2'b00);
    chk("R4 other alarm untouched", alarm_flag[1], 0);
    clear(2'b01);
    chk("R5 cleared", alarm_flag, 0);
    tick();
    chk("R6 no second fire", alarm_flag, 0);
  endtask

  task automatic t_masked_weekday();
    write_alarm(0, mk(2, 0, 0, 0, 0, 0, 0), 7'b100_0000, 1'b1, 1'b0);
    now_time = mk(3, 40, 7, 9, 13, 44, 17);
    tick();
    chk("R3 wrong weekday", alarm_flag, 0);
    now_time = mk(2, 40, 7, 9, 13, 44, 17);
    tick();
    chk("R3 weekday only match", alarm_flag, 2'b01);
    clear(2'b01);
  endtask

  task automatic t_repeat();
    write_alarm(1, mk(0, 0, 0, 0, 0, 0, 0), 7'b000_0001, 1'b1, 1'b1);
    chk("R7 idx1 write leaves alarm0", alarm_armed, 2'b10);
    now_time = mk(4, 10, 5, 5, 8, 12, 0);
    tick();
    chk("R6 repeat fires", alarm_flag, 2'b10);
    chk("R6 repeat stays armed", alarm_armed[1], 1);
    chk("R4 alarm0 not set", alarm_flag[0], 0);
    clear(2'b10);
    now_time = mk(4, 10, 5, 5, 8, 13, 0);
    tick();
    chk("R6 repeat fires again", alarm_flag, 2'b10);
  endtask

  task automatic t_sticky();
    cyc(5);
    chk("R5 flag holds", alarm_flag[1], 1);
    @(negedge clk); clr_flag = 2'b10; sec_tick = 1'b1;
    @(negedge clk); clr_flag = '0; sec_tick = 1'b0;
    chk("R5 set wins over clear", alarm_flag[1], 1);
  endtask

  task automatic t_irq();
    @(negedge clk); out_sel = 2'd0; irq_en = 2'b10;
    @(negedge clk);
    chk("R8 irq high", irq_fout, 1);
    irq_en = 2'b01;
    @(negedge clk);
    chk("R10 disabled irq low", irq_fout, 0);
    chk("R10 flag kept", alarm_flag[1], 1);
  endtask

  task automatic t_fout();
    irq_en = 2'b10;
    @(negedge clk); out_sel = 2'd1; presc = 16'h8000;
    @(negedge clk); chk("R9 1hz high", irq_fout, 1);
    presc = 16'h7FFF;
    @(negedge clk); chk("R9 1hz low", irq_fout, 0);
    out_sel = 2'd2; presc = 16'h0008;
    @(negedge clk); chk("R9 4k high", irq_fout, 1);
    presc = 16'hFFF7;
    @(negedge clk); chk("R9 4k low", irq_fout, 0);
    out_sel = 2'd3; presc = 16'h0001;
    @(negedge clk); chk("R9 32k high", irq_fout, 1);
    presc = 16'hFFFE;
    @(negedge clk); chk("R9 32k low despite flag", irq_fout, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_match_oneshot();
    t_masked_weekday();
    t_repeat();
    t_sticky();
    t_irq();
    t_fout();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule